// File: doc/BRIEF.md
# Dual-Channel Tri-State Phase Detector with Lock Qualification

The block compares, for each of its channels, a divided reference strobe with a divided feedback strobe, one system-clock cycle wide each. It produces the steering triple for an external charge pump: drive-high, drive-low and drive-enable. When drive-enable is low the pump output floats. A per-channel polarity bit sets which sense is driven when the reference leads. The block keeps a per-channel lock flag, which is qualified over several comparisons and dropped quickly on a large error. It merges the flags into one shared lock output. A single status pin carries either that shared lock or one of the raw strobes, which is useful for bring-up.

Each channel has a run input. Pulling run low puts the channel in power save: the pump floats, any pending comparison is discarded and the channel counts as locked in the shared output. When run returns high, or after reset, the first comparison completes silently. No correction pulse comes from an unknown starting phase, so the loop is not kicked. Normal steering starts from the second comparison.

Top module: `pfd_dual_lock`

## Requirements
- R1: While reset is applied and right after it, every pump output is low, each channel's lock flag equals the inverse of its run input, and the shared lock is low if any channel runs.
- R2: With polarity 1, a reference strobe arriving k cycles before its feedback strobe holds drive-high and drive-enable for k cycles, starting the cycle after the reference. A feedback strobe arriving first drives drive-low the same way.
- R3: With polarity 0, the senses of R2 are swapped: a leading reference drives drive-low and a leading feedback drives drive-high.
- R4: Every counted comparison, including one where both strobes arrive in the same cycle, is followed by MIN_PULSE cycles in which drive-high, drive-low and drive-enable are all high.
- R5: While a channel waits for the opposite strobe, further strobes on the side already seen are absorbed. The error is measured from the first one.
- R6: The first comparison after reset or after leaving power save drives no pump output and is not counted for lock.
- R7: With run low, the channel's pump outputs are low in the same cycle, its lock flag is high, and its pending strobe and lock history are cleared. After run returns high, the lock flag stays low until the channel requalifies.
- R8: A channel becomes locked after LOCK_CYCLES consecutive counted comparisons, each with an error of at most LOCK_WIN cycles.
- R9: A locked channel loses lock as soon as one-sided drive has lasted UNLOCK_WIN cycles, without waiting for the opposite strobe.
- R10: A counted comparison whose error lies strictly between LOCK_WIN and UNLOCK_WIN restarts the qualification count and leaves the lock flag unchanged.
- R11: The shared lock output is high exactly when every channel is locked or in power save.
- R12: With mon_sel 0 the status pin shows the shared lock. With mon_sel 1 it shows a raw strobe: tst_sel bit 0 picks the channel, and tst_sel bit 1 picks feedback (1) or reference (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_run | input | NCH | Per-channel run; 0 selects power save |
| chan_pol | input | NCH | Per-channel output polarity |
| ref_pulse | input | NCH | Divided reference strobes |
| fb_pulse | input | NCH | Divided feedback strobes |
| mon_sel | input | 1 | Status pin shows a raw strobe when 1 |
| tst_sel | input | $clog2(NCH)+1 | Strobe selector for the status pin |
| pump_hi | output | NCH | Pump drives high |
| pump_lo | output | NCH | Pump drives low |
| pump_en | output | NCH | Pump drive enable; 0 means float |
| lock_chan | output | NCH | Per-channel lock report |
| lock_all | output | 1 | Combined lock |
| status | output | 1 | Shared status pin |

## Verification
The bench builds the block with LOCK_WIN 1, UNLOCK_WIN 5, LOCK_CYCLES 3 and MIN_PULSE 2. The narrow lock window leaves a mid band of errors from 2 to 4 cycles, so qualification restarts can be seen separately from losses of lock. A five-cycle unlock window can be reached within one stalled comparison. A two-cycle balance pulse exercises the countdown rather than a single flop. Two channels give the full four-way strobe selection and both halves of the combined lock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   typedef enum logic [1:0] {
      PEND_NONE = 2'b00,
      PEND_REF  = 2'b01,
      PEND_FB   = 2'b10
   } pend_e;

   typedef struct packed {
      logic hi;
      logic lo;
      logic en;
   } pump_t;

   function automatic int bits_for(input int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/pfd_chan_core.sv
module pfd_chan_core
   import pfd_pkg::*;
#(
   parameter int MIN_PULSE  = 1,
   parameter int UNLOCK_WIN = 4,
   localparam int ERRW      = bits_for(UNLOCK_WIN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            pol,
   input  logic            ref_p,
   input  logic            fb_p,
   output pump_t           pump,
   output logic            cmp_stb,
   output logic [ERRW-1:0] cmp_err,
   output logic            wait_act,
   output logic [ERRW-1:0] wait_err
);

   localparam logic [ERRW-1:0] AGE_MAX = ERRW'(UNLOCK_WIN);

   pend_e           pend_q, pend_d;
   logic [ERRW-1:0] age_q, age_d;
   logic            skip_q, skip_d;
   logic            have_ref, have_fb, done;
   logic            waiting, active, lead, lag, bal_on;

   assign have_ref = (pend_q == PEND_REF) | ref_p;
   assign have_fb  = (pend_q == PEND_FB) | fb_p;
   assign done     = have_ref & have_fb;
   assign waiting  = (pend_q != PEND_NONE);
   assign active   = run & ~skip_q;
   assign lead     = (pend_q == PEND_REF);
   assign lag      = (pend_q == PEND_FB);

   always_comb begin
      pend_d = pend_q;
      age_d  = age_q;
      skip_d = skip_q;
      if (!run) begin
         pend_d = PEND_NONE;
         age_d  = '0;
         skip_d = 1'b1;
      end else if (done) begin
         pend_d = PEND_NONE;
         age_d  = '0;
         skip_d = 1'b0;
      end else if (!waiting) begin
         if (ref_p)     pend_d = PEND_REF;
         else if (fb_p) pend_d = PEND_FB;
         age_d = '0;
      end else if (age_q < AGE_MAX) begin
         age_d = age_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= PEND_NONE;
         age_q  <= '0;
         skip_q <= 1'b1;
      end else begin
         pend_q <= pend_d;
         age_q  <= age_d;
         skip_q <= skip_d;
      end
   end

   assign wait_err = age_q + 1'b1;
   assign cmp_err  = waiting ? wait_err : '0;
   assign cmp_stb  = active & done;
   assign wait_act = active & waiting;

   generate
      if (MIN_PULSE > 0) begin : g_bal
         localparam int BW = bits_for(MIN_PULSE);
         logic [BW-1:0] bal_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            bal_q <= '0;
            else if (!run)         bal_q <= '0;
            else if (cmp_stb)      bal_q <= BW'(MIN_PULSE);
            else if (bal_q != '0)  bal_q <= bal_q - 1'b1;
         end
         assign bal_on = (bal_q != '0);
      end else begin : g_nobal
         assign bal_on = 1'b0;
      end
   endgenerate

   assign pump.hi = active & ((pol ? lead : lag) | bal_on);
   assign pump.lo = active & ((pol ? lag : lead) | bal_on);
   assign pump.en = pump.hi | pump.lo;

endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual
   import pfd_pkg::*;
#(
   parameter int LOCK_WIN    = 2,
   parameter int UNLOCK_WIN  = 4,
   parameter int LOCK_CYCLES = 3,
   localparam int ERRW       = bits_for(UNLOCK_WIN + 1),
   localparam int GW         = bits_for(LOCK_CYCLES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            cmp_stb,
   input  logic [ERRW-1:0] cmp_err,
   input  logic            wait_act,
   input  logic [ERRW-1:0] wait_err,
   output logic            locked
);

   localparam logic [ERRW-1:0] LWIN  = ERRW'(LOCK_WIN);
   localparam logic [ERRW-1:0] UWIN  = ERRW'(UNLOCK_WIN);
   localparam logic [GW-1:0]   GMAX  = GW'(LOCK_CYCLES);
   localparam logic [GW-1:0]   GLAST = GW'(LOCK_CYCLES - 1);

   logic [GW-1:0] good_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_q <= '0;
         locked <= 1'b0;
      end else if (!run) begin
         good_q <= '0;
         locked <= 1'b0;
      end else if (wait_act && (wait_err >= UWIN)) begin
         good_q <= '0;
         locked <= 1'b0;
      end else if (cmp_stb) begin
         if (cmp_err <= LWIN) begin
            if (good_q < GMAX)   good_q <= good_q + 1'b1;
            if (good_q >= GLAST) locked <= 1'b1;
         end else begin
            good_q <= '0;
         end
      end
   end

endmodule

// File: rtl/pfd_status_sel.sv
module pfd_status_sel #(
   parameter int NCH   = 2,
   localparam int CW   = $clog2(NCH),
   localparam int SELW = CW + 1
) (
   input  logic [NCH-1:0]  lock_rep,
   input  logic [NCH-1:0]  ref_p,
   input  logic [NCH-1:0]  fb_p,
   input  logic            mon_sel,
   input  logic [SELW-1:0] tst_sel,
   output logic            lock_all,
   output logic            status
);

   logic [CW-1:0] ch;
   logic          use_fb;
   logic          mon;

   assign ch       = tst_sel[CW-1:0];
   assign use_fb   = tst_sel[SELW-1];
   assign mon      = use_fb ? fb_p[ch] : ref_p[ch];
   assign lock_all = &lock_rep;
   assign status   = mon_sel ? mon : lock_all;

endmodule

// File: rtl/pfd_dual_lock.sv
module pfd_dual_lock
   import pfd_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int LOCK_WIN    = 2,
   parameter int UNLOCK_WIN  = 4,
   parameter int LOCK_CYCLES = 3,
   parameter int MIN_PULSE   = 1,
   localparam int SELW       = $clog2(NCH) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCH-1:0]  chan_run,
   input  logic [NCH-1:0]  chan_pol,
   input  logic [NCH-1:0]  ref_pulse,
   input  logic [NCH-1:0]  fb_pulse,
   input  logic            mon_sel,
   input  logic [SELW-1:0] tst_sel,
   output logic [NCH-1:0]  pump_hi,
   output logic [NCH-1:0]  pump_lo,
   output logic [NCH-1:0]  pump_en,
   output logic [NCH-1:0]  lock_chan,
   output logic            lock_all,
   output logic            status
);

   localparam int ERRW = bits_for(UNLOCK_WIN + 1);

   generate
      if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
         $error("NCH must be a power of two and at least 2");
      end
      if (LOCK_WIN < 0 || LOCK_WIN >= UNLOCK_WIN) begin : g_bad_win
         $error("LOCK_WIN must be below UNLOCK_WIN");
      end
      if (LOCK_CYCLES < 1) begin : g_bad_qual
         $error("LOCK_CYCLES must be at least 1");
      end
      if (MIN_PULSE < 0) begin : g_bad_pulse
         $error("MIN_PULSE must not be negative");
      end
   endgenerate

   logic [NCH-1:0] lock_rep;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         pump_t           pump;
         logic            cmp_stb, wait_act, locked;
         logic [ERRW-1:0] cmp_err, wait_err;

         pfd_chan_core #(
            .MIN_PULSE (MIN_PULSE),
            .UNLOCK_WIN(UNLOCK_WIN)
         ) u_core (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (chan_run[c]),
            .pol     (chan_pol[c]),
            .ref_p   (ref_pulse[c]),
            .fb_p    (fb_pulse[c]),
            .pump    (pump),
            .cmp_stb (cmp_stb),
            .cmp_err (cmp_err),
            .wait_act(wait_act),
            .wait_err(wait_err)
         );

         pfd_lock_qual #(
            .LOCK_WIN   (LOCK_WIN),
            .UNLOCK_WIN (UNLOCK_WIN),
            .LOCK_CYCLES(LOCK_CYCLES)
         ) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (chan_run[c]),
            .cmp_stb (cmp_stb),
            .cmp_err (cmp_err),
            .wait_act(wait_act),
            .wait_err(wait_err),
            .locked  (locked)
         );

         assign pump_hi[c]  = pump.hi;
         assign pump_lo[c]  = pump.lo;
         assign pump_en[c]  = pump.en;
         assign lock_rep[c] = ~chan_run[c] | locked;
      end
   endgenerate

   assign lock_chan = lock_rep;

   pfd_status_sel #(.NCH(NCH)) u_sel (
      .lock_rep(lock_rep),
      .ref_p   (ref_pulse),
      .fb_p    (fb_pulse),
      .mon_sel (mon_sel),
      .tst_sel (tst_sel),
      .lock_all(lock_all),
      .status  (status)
   );

endmodule

// File: rtl/pfd_dual_lock_chk.sv
module pfd_dual_lock_chk #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] chan_run,
   input logic [NCH-1:0] ref_pulse,
   input logic [NCH-1:0] fb_pulse,
   input logic [NCH-1:0] pump_en,
   input logic [NCH-1:0] lock_chan
);

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         // R7: a saved channel floats its pump and reports locked
         a_r7_save_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_run[c] |-> (!pump_en[c] && lock_chan[c]));

         // R6: no steering at the moment a channel leaves power save
         a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chan_run[c]) |-> !pump_en[c]);

         // R8: lock is only gained on a comparison, which needs a strobe
         a_r8_lock_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(lock_chan[c]) && chan_run[c] && $past(chan_run[c]))
            |-> $past(ref_pulse[c] || fb_pulse[c]));

         // R9: lock is only lost while steering, or on leaving power save
         a_r9_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lock_chan[c]) |-> ($past(pump_en[c]) || $rose(chan_run[c])));
      end
   endgenerate

endmodule

bind pfd_dual_lock pfd_dual_lock_chk #(.NCH(NCH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .chan_run (chan_run),
   .ref_pulse(ref_pulse),
   .fb_pulse (fb_pulse),
   .pump_en  (pump_en),
   .lock_chan(lock_chan)
);

// File: tb/sim_pfd_dual_lock.sv
`timescale 1ns/1ps
module sim_pfd_dual_lock;

   localparam int NCH = 2;
   localparam int LW  = 1;
   localparam int UW  = 5;
   localparam int LC  = 3;
   localparam int MP  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] run = 2'b11;
   logic [1:0] pol = 2'b11;
   logic [1:0] rp = 2'b00;
   logic [1:0] fp = 2'b00;
   logic       mon = 1'b0;
   logic [1:0] tst = 2'b00;
   logic [1:0] hi, lo, en, lkc;
   logic       lka, st;

   always #2 clk = ~clk;

   pfd_dual_lock #(
      .NCH(NCH), .LOCK_WIN(LW), .UNLOCK_WIN(UW), .LOCK_CYCLES(LC), .MIN_PULSE(MP)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .chan_run(run), .chan_pol(pol),
      .ref_pulse(rp), .fb_pulse(fp), .mon_sel(mon), .tst_sel(tst),
      .pump_hi(hi), .pump_lo(lo), .pump_en(en), .lock_chan(lkc),
      .lock_all(lka), .status(st)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   bit    finished = 0;
   string req = "R1";

   // reference model state per channel: pend 0 none, 1 reference seen, 2 feedback seen
   int pend [NCH] = '{0, 0};
   int age  [NCH] = '{0, 0};
   int skp  [NCH] = '{1, 1};
   int bal  [NCH] = '{0, 0};
   int good [NCH] = '{0, 0};
   int lk   [NCH] = '{0, 0};

   task automatic chk1(input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic model_step();
      for (int c = 0; c < NCH; c++) begin
         if (!rst_n || !run[c]) begin
            pend[c] = 0; age[c] = 0; skp[c] = 1; bal[c] = 0; good[c] = 0; lk[c] = 0;
         end else begin
            bit hr, hf, unl;
            int err, nb;
            hr  = (pend[c] == 1) || rp[c];
            hf  = (pend[c] == 2) || fp[c];
            err = (pend[c] != 0) ? age[c] + 1 : 0;
            unl = (skp[c] == 0) && (pend[c] != 0) && (age[c] + 1 >= UW);
            nb  = (bal[c] > 0) ? bal[c] - 1 : 0;
            if (unl) begin lk[c] = 0; good[c] = 0; end
            if (hr && hf) begin
               if (skp[c] == 0) begin
                  nb = MP;
                  if (!unl) begin
                     if (err <= LW) begin
                        if (good[c] < LC) good[c]++;
                        if (good[c] >= LC) lk[c] = 1;
                     end else begin
                        good[c] = 0;
                     end
                  end
               end
               pend[c] = 0; age[c] = 0; skp[c] = 0;
            end else if (pend[c] == 0) begin
               pend[c] = rp[c] ? 1 : (fp[c] ? 2 : 0);
               age[c]  = 0;
            end else begin
               age[c]++;
            end
            bal[c] = nb;
         end
      end
   endtask

   task automatic compare();
      logic all;
      logic es;
      all = 1'b1;
      for (int c = 0; c < NCH; c++) begin
         logic act, lead, lag, bl, eh, el, el_k;
         act  = run[c] && (skp[c] == 0);
         lead = (pend[c] == 1);
         lag  = (pend[c] == 2);
         bl   = (bal[c] > 0);
         eh   = act && ((pol[c] ? lead : lag) || bl);
         el   = act && ((pol[c] ? lag : lead) || bl);
         el_k = !run[c] || (lk[c] != 0);
         chk1($sformatf("pump_hi[%0d]", c), hi[c], eh);
         chk1($sformatf("pump_lo[%0d]", c), lo[c], el);
         chk1($sformatf("pump_en[%0d]", c), en[c], eh || el);
         chk1($sformatf("lock_chan[%0d]", c), lkc[c], el_k);
         all = all & el_k;
      end
      chk1("lock_all", lka, all);
      es = mon ? (tst[1] ? fp[tst[0]] : rp[tst[0]]) : all;
      chk1("status", st, es);
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic pulse_pair(input int c, input int off, input int gap);
      if (off == 0) begin
         rp[c] = 1'b1; fp[c] = 1'b1; tick(); rp[c] = 1'b0; fp[c] = 1'b0;
      end else if (off > 0) begin
         rp[c] = 1'b1; tick(); rp[c] = 1'b0;
         repeat (off - 1) tick();
         fp[c] = 1'b1; tick(); fp[c] = 1'b0;
      end else begin
         fp[c] = 1'b1; tick(); fp[c] = 1'b0;
         repeat (-off - 1) tick();
         rp[c] = 1'b1; tick(); rp[c] = 1'b0;
      end
      repeat (gap) tick();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      logic [15:0] lfsr;
      req = "R1";
      repeat (3) tick();
      rst_n = 1'b1;
      repeat (2) tick();

      req = "R6";
      pulse_pair(0, 3, 3);
      pulse_pair(1, 2, 3);

      req = "R2";
      pulse_pair(0, 2, 4);
      pulse_pair(0, -3, 4);

      req = "R4";
      pulse_pair(0, 0, 4);

      req = "R3";
      pol[0] = 1'b0;
      pulse_pair(0, 2, 4);
      pulse_pair(0, -2, 4);
      pol[0] = 1'b1;

      req = "R8";
      pulse_pair(0, 1, 3);
      pulse_pair(0, 1, 3);
      chk1("lock_chan[0] before third good comparison", lkc[0], 1'b0);
      pulse_pair(0, -1, 3);
      chk1("lock_chan[0] after third good comparison", lkc[0], 1'b1);

      req = "R10";
      pulse_pair(1, 1, 3);
      pulse_pair(1, 1, 3);
      pulse_pair(1, 3, 3);
      pulse_pair(1, 1, 3);
      pulse_pair(1, -1, 3);
      chk1("lock_chan[1] after restarted count", lkc[1], 1'b0);
      pulse_pair(1, 0, 3);
      chk1("lock_chan[1] after requalifying", lkc[1], 1'b1);
      pulse_pair(1, 3, 3);
      chk1("lock_chan[1] kept through mid-band error", lkc[1], 1'b1);

      req = "R11";
      chk1("lock_all with both locked", lka, 1'b1);

      req = "R9";
      rp[0] = 1'b1; tick(); rp[0] = 1'b0;
      repeat (6) tick();
      chk1("lock_chan[0] before feedback arrives", lkc[0], 1'b0);
      fp[0] = 1'b1; tick(); fp[0] = 1'b0;
      repeat (4) tick();

      req = "R5";
      rp[0] = 1'b1; tick(); rp[0] = 1'b0;
      tick();
      rp[0] = 1'b1; tick(); rp[0] = 1'b0;
      fp[0] = 1'b1; tick(); fp[0] = 1'b0;
      repeat (4) tick();

      req = "R7";
      rp[0] = 1'b1; tick(); rp[0] = 1'b0;
      tick();
      run[0] = 1'b0;
      tick();
      chk1("pump_en[0] in power save", en[0], 1'b0);
      req = "R11";
      chk1("lock_all with one channel saved", lka, 1'b1);
      req = "R7";
      fp[0] = 1'b1; tick(); fp[0] = 1'b0;
      repeat (2) tick();
      run[0] = 1'b1;
      tick();
      chk1("lock_chan[0] after leaving power save", lkc[0], 1'b0);
      pulse_pair(0, 2, 3);
      pulse_pair(0, 1, 3);

      req = "R12";
      mon = 1'b1;
      for (int s = 0; s < 4; s++) begin
         tst = 2'(s);
         for (int p = 0; p < 4; p++) begin
            if (p < 2) rp[p] = 1'b1; else fp[p-2] = 1'b1;
            tick();
            rp = 2'b00; fp = 2'b00;
            tick();
         end
      end
      mon = 1'b0;
      repeat (3) tick();

      req = "R2";
      lfsr = 16'hACE1;
      for (int i = 0; i < 1500; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rp = {lfsr[2:0] == 3'd0, lfsr[5:3] == 3'd0};
         fp = {lfsr[8:6] == 3'd0, lfsr[11:9] == 3'd0};
         if (lfsr[15:10] == 6'd0) run[lfsr[0]] = ~run[lfsr[0]];
         if (lfsr[15:9] == 7'd5) pol[lfsr[1]] = ~pol[lfsr[1]];
         mon = (lfsr[14:12] == 3'd7);
         tst = lfsr[4:3];
         tick();
      end
      rp = 2'b00; fp = 2'b00; run = 2'b11; mon = 1'b0;
      repeat (4) tick();

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL %s watchdog: actual running expected finished", req);
         summary();
         $finish;
      end
   end

endmodule